// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair

This block sits between a processor-side register port and the serial shifters of a UART. It holds two byte queues of 16 entries each. Software writes outgoing bytes into the transmit queue through one register address. It reads incoming bytes from the receive queue through another address. The shifters themselves live outside the block. Each one is seen as a byte stream with a valid/ready handshake: the transmit side offers bytes to the serialiser, and the receive side accepts bytes from the deserialiser.

Each direction has its own control word. The word holds an enable, a one-shot flush command and a 6-bit trigger level, which drives one interrupt request line per direction. A single status word reports the receive fill level, the transmit fill level and the number of free transmit entries, so a driver can size a burst of writes from one read. The normal driver setting is a trigger level of 1 in both directions.

The register port is synchronous, with separate read and write strobes, a 3-bit word address and 32-bit data. Read data is registered.

Top module: `serial_fifo_pair`

## Requirements
- R1: After reset, both queues are disabled and empty. Both control words read 0, `tx_valid`, `rx_ready`, `tx_irq` and `rx_irq` are low, and `bus_rdata` is 0.
- R2: The transmit queue holds 16 bytes and presents them on `tx_data` in write order. Address 0 is the transmit data register: a write to it pushes `bus_wdata[7:0]`. A byte leaves the queue on a cycle in which `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R3: A write to address 0 while the transmit free count is zero is dropped, and the queue contents are unchanged.
- R4: Address 1 is the receive data register. `rx_ready` is high while the receive queue is enabled and not full, and a byte is stored on a cycle in which `rx_valid` and `rx_ready` are both high. A read of address 1 returns the oldest byte in bits 7:0 and removes it. A read while the queue is empty returns 0 and changes nothing.
- R5: Address 2 is the transmit control word and address 3 the receive control word. In each, bit 0 is the enable and bit 1 the flush command, and bits 13:8 hold the trigger level. A read returns the stored enable and level, and bit 1 always reads 0.
- R6: A control write with bit 1 set empties that queue, and the fill level reads 0 on the next cycle.
- R7: Address 4 is the status word. Bits 5:0 give the receive fill level, bits 13:8 the transmit fill level, and bits 29:24 the transmit free count, which is 16 minus the transmit fill level while the transmit queue is enabled. All other bits read 0.
- R8: The transmit fill level reads zero exactly when `tx_valid` is low, that is, when no byte waits for the serialiser.
- R9: `rx_irq` is high exactly when the receive queue is enabled and its fill level is at or above its trigger level.
- R10: `tx_irq` is high exactly when the transmit queue is enabled and its fill level is at or below its trigger level.
- R11: While a queue is disabled, its pushes are ignored, its fill level and free count read 0, and its stream handshake output stays low. A control write that clears the enable discards the queue's contents.
- R12: A read presents its data on `bus_rdata` one cycle after the read strobe, and `bus_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit byte available for the serialiser |
| tx_ready | input | 1 | Serialiser takes the byte |
| tx_data | output | 8 | Byte at the head of the transmit queue |
| rx_valid | input | 1 | Deserialiser offers a byte |
| rx_ready | output | 1 | Receive queue can accept a byte |
| rx_data | input | 8 | Byte from the deserialiser |
| tx_irq | output | 1 | Transmit trigger-level request |
| rx_irq | output | 1 | Receive trigger-level request |

## Verification
The hardest cases to reach from the ports are the ones where a bus access meets a stream handshake in the same cycle. Examples are a transmit write landing on a full queue while the serialiser drains a byte, a control write that disables or flushes a queue while a byte is handshaken, and a read of an empty receive queue while a new byte arrives. Directed sequences first fill each queue to its limit with the stream side stalled. A long random phase then mixes bus operations of every kind with randomly toggled `tx_ready` and `rx_valid`, occasional flushes and level changes, and lands on these coincidences many times. Every output is compared each cycle against a queue-based model.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // Register word addresses
  typedef enum logic [2:0] {
    ADDR_TXDATA = 3'd0,
    ADDR_RXDATA = 3'd1,
    ADDR_TXCTL  = 3'd2,
    ADDR_RXCTL  = 3'd3,
    ADDR_STATUS = 3'd4
  } reg_addr_e;

  // Control word fields
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_FLUSH_BIT = 1;
  localparam int CTL_LVL_LSB   = 8;
  localparam int LVL_W         = 6;

  // Status word fields
  localparam int FLD_W        = 6;
  localparam int ST_RXFILL_LSB = 0;
  localparam int ST_TXFILL_LSB = 8;
  localparam int ST_TXFREE_LSB = 24;

  function automatic logic [31:0] pack_status(input logic [FLD_W-1:0] rx_fill,
                                              input logic [FLD_W-1:0] tx_fill,
                                              input logic [FLD_W-1:0] tx_free);
    logic [31:0] w;
    w = '0;
    w[ST_RXFILL_LSB +: FLD_W] = rx_fill;
    w[ST_TXFILL_LSB +: FLD_W] = tx_fill;
    w[ST_TXFREE_LSB +: FLD_W] = tx_free;
    return w;
  endfunction

  function automatic logic [31:0] pack_ctl(input logic en, input logic [LVL_W-1:0] lvl);
    logic [31:0] w;
    w = '0;
    w[CTL_EN_BIT] = en;
    w[CTL_LVL_LSB +: LVL_W] = lvl;
    return w;
  endfunction

endpackage

// File: rtl/sfp_rst_sync.sv
module sfp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0]  count_d;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // Storage: no reset, write enable only
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // R2: occupancy never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3: a push into a full queue with no pop leaves the level unchanged
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count)));

  // R6: a clear empties the queue on the next cycle
  p_clr_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/sfp_fifo_ctl.sv
module sfp_fifo_ctl
  import sfp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wr_en_bit,
  input  logic             wr_flush_bit,
  input  logic [LVL_W-1:0] wr_lvl,
  output logic             en,
  output logic [LVL_W-1:0] lvl,
  output logic             clr
);
  logic             en_d;
  logic [LVL_W-1:0] lvl_d;

  always_comb begin
    en_d  = en;
    lvl_d = lvl;
    if (wr) begin
      en_d  = wr_en_bit;
      lvl_d = wr_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      lvl <= '0;
    end else if (wr) begin
      en  <= en_d;
      lvl <= lvl_d;
    end
  end

  // Flush is a pulse, never stored; disabling also discards contents
  assign clr = !en || (wr && (wr_flush_bit || !wr_en_bit));

  // R5: the stored enable follows the written bit 0
  p_en_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en == $past(wr_en_bit)));
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import sfp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic srst_n;
  logic wr_txd, wr_txc, wr_rxc, rd_rxd;
  logic tx_en, rx_en, tx_clr, rx_clr;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_free;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic [31:0] rdata_d;
  logic unused_wdata;

  sfp_rst_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  // Address decode
  always_comb begin
    wr_txd = bus_wr && (bus_addr == ADDR_TXDATA);
    wr_txc = bus_wr && (bus_addr == ADDR_TXCTL);
    wr_rxc = bus_wr && (bus_addr == ADDR_RXCTL);
    rd_rxd = bus_rd && (bus_addr == ADDR_RXDATA);
  end

  assign unused_wdata = ^bus_wdata[31:CTL_LVL_LSB+LVL_W];

  sfp_fifo_ctl u_tx_ctl (
    .clk(clk), .rst_n(srst_n), .wr(wr_txc),
    .wr_en_bit(bus_wdata[CTL_EN_BIT]), .wr_flush_bit(bus_wdata[CTL_FLUSH_BIT]),
    .wr_lvl(bus_wdata[CTL_LVL_LSB +: LVL_W]),
    .en(tx_en), .lvl(tx_lvl), .clr(tx_clr)
  );

  sfp_fifo_ctl u_rx_ctl (
    .clk(clk), .rst_n(srst_n), .wr(wr_rxc),
    .wr_en_bit(bus_wdata[CTL_EN_BIT]), .wr_flush_bit(bus_wdata[CTL_FLUSH_BIT]),
    .wr_lvl(bus_wdata[CTL_LVL_LSB +: LVL_W]),
    .en(rx_en), .lvl(rx_lvl), .clr(rx_clr)
  );

  sfp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
    .clk(clk), .rst_n(srst_n), .clr(tx_clr),
    .push(wr_txd && tx_en), .push_data(bus_wdata[DATA_W-1:0]),
    .pop(tx_valid && tx_ready),
    .head(tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  sfp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
    .clk(clk), .rst_n(srst_n), .clr(rx_clr),
    .push(rx_valid && rx_ready), .push_data(rx_data),
    .pop(rd_rxd),
    .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // Stream handshakes
  assign tx_valid = tx_en && !tx_empty;
  assign rx_ready = rx_en && !rx_full;
  assign tx_free  = tx_en ? (CNT_W'(DEPTH) - tx_cnt) : '0;

  // Trigger-level requests
  assign rx_irq = rx_en && (LVL_W'(rx_cnt) >= rx_lvl);
  assign tx_irq = tx_en && (LVL_W'(tx_cnt) <= rx_lvl_sel_tx());

  function automatic logic [LVL_W-1:0] rx_lvl_sel_tx();
    return tx_lvl;
  endfunction

  // Read data mux and register
  always_comb begin
    rdata_d = '0;
    unique case (bus_addr)
      ADDR_RXDATA: rdata_d = rx_empty ? '0 : 32'(rx_head);
      ADDR_TXCTL:  rdata_d = pack_ctl(tx_en, tx_lvl);
      ADDR_RXCTL:  rdata_d = pack_ctl(rx_en, rx_lvl);
      ADDR_STATUS: rdata_d = pack_status(FLD_W'(rx_cnt), FLD_W'(tx_cnt), FLD_W'(tx_free));
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  // R11: a disabled queue is empty
  p_tx_disabled_empty_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !tx_en |-> (tx_cnt == '0));
  p_rx_disabled_empty_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !rx_en |-> (rx_cnt == '0));

  // R12: read data holds between reads
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R4: reading an empty receive queue returns zero
  p_rx_empty_read_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_rxd && rx_empty) |=> (bus_rdata == '0));

  // R2: a stalled transmit byte stays put
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && !tx_ready && !tx_clr) |=> (tx_valid && $stable(tx_data)));

  // R10: transmit request never raised while disabled
  p_tx_irq_en_r10: assert property (@(posedge clk) disable iff (!srst_n)
    tx_irq |-> tx_en);
endmodule

// File: tb/serial_fifo_pair_tb_top.sv
module serial_fifo_pair_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_rd, bus_wr, tx_valid, tx_ready, rx_valid, rx_ready, tx_irq, rx_irq;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_data, rx_data;

  serial_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int n_chk = 0, n_bad = 0;

  // Reference model state
  logic [7:0]  txq[$], rxq[$];
  logic        ten = 1'b0, ren = 1'b0;
  logic [5:0]  tlvl = '0, rlvl = '0;
  logic [31:0] exp_rd = '0;
  string       rd_tag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_status();
    logic [31:0] w;
    w = '0;
    w[5:0]   = 6'(rxq.size());
    w[13:8]  = 6'(txq.size());
    w[29:24] = ten ? 6'(16 - txq.size()) : 6'd0;
    return w;
  endfunction

  task automatic model_step(input bit rd, input bit wr, input logic [2:0] a,
                            input logic [31:0] d, input bit trdy, input bit rvld,
                            input logic [7:0] rdat);
    int tpre, rpre;
    tpre = txq.size();
    rpre = rxq.size();
    if (rd) begin
      case (a)
        3'd1: begin exp_rd = (rpre > 0) ? {24'h0, rxq[0]} : 32'h0; rd_tag = "R4"; end
        3'd2: begin exp_rd = {18'h0, tlvl, 7'h0, ten}; rd_tag = "R5"; end
        3'd3: begin exp_rd = {18'h0, rlvl, 7'h0, ren}; rd_tag = "R5"; end
        3'd4: begin exp_rd = model_status(); rd_tag = "R7"; end
        default: begin exp_rd = 32'h0; rd_tag = "R12"; end
      endcase
    end else rd_tag = "R12";
    if (ten && tpre > 0 && trdy) void'(txq.pop_front());
    if (wr && a == 3'd0 && ten && tpre < 16) txq.push_back(d[7:0]);
    if (rd && a == 3'd1 && rpre > 0) void'(rxq.pop_front());
    if (rvld && ren && rpre < 16) rxq.push_back(rdat);
    if (wr && a == 3'd2) begin
      if (!d[0] || d[1]) txq.delete();
      ten = d[0]; tlvl = d[13:8];
    end
    if (wr && a == 3'd3) begin
      if (!d[0] || d[1]) rxq.delete();
      ren = d[0]; rlvl = d[13:8];
    end
  endtask

  task automatic compare_all();
    logic ev;
    ev = ten && (txq.size() > 0);
    chk("R8", 32'(tx_valid), 32'(ev));
    if (ev) chk("R2", 32'(tx_data), 32'(txq[0]));
    chk(ren ? "R4" : "R11", 32'(rx_ready), 32'(ren && rxq.size() < 16));
    chk("R10", 32'(tx_irq), 32'(ten && txq.size() <= int'(tlvl)));
    chk("R9", 32'(rx_irq), 32'(ren && rxq.size() >= int'(rlvl)));
    chk(rd_tag, bus_rdata, exp_rd);
  endtask

  task automatic cyc(input bit rd, input bit wr, input logic [2:0] a, input logic [31:0] d,
                     input bit trdy, input bit rvld, input logic [7:0] rdat);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    tx_ready = trdy; rx_valid = rvld; rx_data = rdat;
    model_step(rd, wr, a, d, trdy, rvld, rdat);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, a, d, 1'b0, 1'b0, 8'h0);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, 1'b0, 8'h0);
    v = bus_rdata;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    tx_ready = 0; rx_valid = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", {28'h0, tx_valid, rx_ready, tx_irq, rx_irq}, 32'h0);
    chk("R1", bus_rdata, 32'h0);
    rd_reg(3'd2, v); chk("R1", v, 32'h0);
    rd_reg(3'd4, v); chk("R1", v, 32'h0);

    // R11: disabled queues ignore pushes on both sides
    cyc(1'b0, 1'b1, 3'd0, 32'hAA, 1'b0, 1'b1, 8'h55);
    rd_reg(3'd4, v); chk("R11", v, 32'h0);

    // R5: enable both, level 1
    wr_reg(3'd2, 32'h0000_0101);
    wr_reg(3'd3, 32'h0000_0101);
    rd_reg(3'd2, v); chk("R5", v, 32'h0000_0101);

    // R3: 18 pushes with the serialiser stalled, two dropped
    for (int i = 0; i < 18; i++) cyc(1'b0, 1'b1, 3'd0, 32'((i + 1) * 7), 1'b0, 1'b0, 8'h0);
    rd_reg(3'd4, v); chk("R3", v, 32'h0000_1000);
    chk("R10", 32'(tx_irq), 32'h0);

    // R2: drain in order
    for (int i = 0; i < 17; i++) cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b0, 8'h0);
    rd_reg(3'd4, v); chk("R7", v, 32'h1000_0000);
    chk("R8", 32'(tx_valid), 32'h0);

    // R4: fill receive queue past full, then read all and one extra
    for (int i = 0; i < 18; i++) cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b1, 8'(8'h30 + i));
    rd_reg(3'd4, v); chk("R4", v, 32'h1000_0010);
    for (int i = 0; i < 16; i++) begin rd_reg(3'd1, v); chk("R4", v, 32'(8'h30 + i)); end
    rd_reg(3'd1, v); chk("R4", v, 32'h0);

    // R6: flush transmit queue holding five bytes
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 3'd0, 32'(8'hC0 + i), 1'b0, 1'b0, 8'h0);
    wr_reg(3'd2, 32'h0000_0103);
    rd_reg(3'd4, v); chk("R6", v, 32'h1000_0000);
    rd_reg(3'd2, v); chk("R5", v, 32'h0000_0101);

    // R9: receive level 4
    wr_reg(3'd3, 32'h0000_0401);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b1, 8'(i));
    chk("R9", 32'(rx_irq), 32'h0);
    cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b1, 8'h3);
    chk("R9", 32'(rx_irq), 32'h1);

    // R10: transmit level 3
    wr_reg(3'd2, 32'h0000_0301);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 3'd0, 32'(i), 1'b0, 1'b0, 8'h0);
    chk("R10", 32'(tx_irq), 32'h0);
    cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b0, 8'h0);
    chk("R10", 32'(tx_irq), 32'h1);

    // R11: disabling discards contents
    wr_reg(3'd2, 32'h0000_0300);
    wr_reg(3'd3, 32'h0000_0000);
    rd_reg(3'd4, v); chk("R11", v, 32'h0);
    chk("R11", {30'h0, tx_valid, rx_ready}, 32'h0);

    // Random mix against the model
    wr_reg(3'd2, 32'h0000_0101);
    wr_reg(3'd3, 32'h0000_0101);
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom % 8;
      d  = 32'($urandom);
      case (op)
        0, 1, 2: cyc(1'b0, 1'b1, 3'd0, d, 1'($urandom % 3 == 0), 1'($urandom), 8'($urandom));
        3:       cyc(1'b1, 1'b0, 3'd1, d, 1'($urandom), 1'($urandom), 8'($urandom));
        4:       cyc(1'b1, 1'b0, 3'($urandom % 5), d, 1'($urandom), 1'($urandom), 8'($urandom));
        5: begin
          logic [31:0] c;
          c = {18'h0, 6'($urandom % 18), 6'h0, 1'($urandom % 6 == 0), 1'($urandom % 8 != 0)};
          if ($urandom % 10 == 0) cyc(1'b0, 1'b1, 3'(2 + $urandom % 2), c, 1'($urandom), 1'($urandom), 8'($urandom));
          else cyc(1'b0, 1'b0, 3'd0, d, 1'($urandom), 1'($urandom), 8'($urandom));
        end
        default: cyc(1'b0, 1'b0, 3'd0, d, 1'($urandom), 1'($urandom), 8'($urandom));
      endcase
    end

    summary();
    $finish;
  end
endmodule